// File: doc/BRIEF.md
# SMI Status Aggregator

This block gathers the causes of a system-management interrupt into one 16-bit top-level status word, which is read over a small register bus. Four of the bits are local sticky flags: software request, A20 gate toggle, VGA timer expiry and video retrace. A one-cycle pulse sets each flag, three of the flags are gated by an enable, and a read of the top-level word clears all four. The other bits summarise lower-level status groups: timers and traps, LPC, ACPI register access, audio and power management. Each of these is 1 while any bit of its group's pending vector is 1, and a read of the top level never clears them. The group's own servicing logic clears them.

Eight active-low external SMI inputs each pass through a synchronizer and a falling-edge detector. A detected edge sets a per-pin pending bit. The pending bits are visible at a second address and are cleared there by writing ones. Their OR forms one summary bit of the top-level word. The block drives an SMI request output for as long as any top-level bit is 1.

Top module: `smi_status_hub`

## Requirements
- R1: While reset is active and after its release, `busRdata` is 0, `smiReq` is 0, and every flag and external pending bit is 0.
- R2: A `swSmiPulse` sets bit 8 of the top-level word (address 0). A read of address 0 returns the bit and clears it.
- R3: `a20TogglePulse`, `vgaTimerPulse` and `retracePulse` set bits 7, 6 and 5 respectively, but only when `flagEnable[2]`, `flagEnable[1]` and `flagEnable[0]` respectively are 1. A read of address 0 clears these bits.
- R4: If a set pulse arrives in the same cycle as a clearing read of address 0, the flag is still 1 afterwards. The read returns the value the word had before that cycle.
- R5: Bits 9, 3, 2, 1 and 0 are the OR of `timerPending`, `lpcPending`, `acpiPending`, `audioPending` and `pmPending` respectively. Reading address 0 does not change them.
- R6: Each `extSmiN[i]` is synchronized through two flops. A 1-to-0 transition sets pending bit i at most three clock edges after the input changes. A rising edge or a steady low level sets nothing.
- R7: Address 1 returns the external pending bits, with bit i for pin i, and reading it does not clear them. A write to address 1 clears each pending bit whose data bit is 1. Bit 10 of the top-level word is the OR of the pending bits, and a read of address 0 does not clear it.
- R8: Bits 15 to 11 and bit 4 of the top-level word always read 0. A write to address 0 has no effect.
- R9: `smiReq` is 1 exactly while any bit of the top-level word is 1.
- R10: Read data appears on `busRdata` in the cycle after `busRd` is sampled. Unmapped addresses read 0, and `busRdata` is 0 in the cycle after any clock edge at which no read was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register address (0 top-level word, 1 external pending) |
| busRd | input | 1 | Read strobe, sampled on the clock edge |
| busWr | input | 1 | Write strobe, sampled on the clock edge |
| busWdata | input | 16 | Write data (clear mask at address 1) |
| busRdata | output | 16 | Registered read data |
| swSmiPulse | input | 1 | Software SMI request pulse |
| a20TogglePulse | input | 1 | A20 gate toggle request pulse |
| vgaTimerPulse | input | 1 | VGA timer expiry pulse |
| retracePulse | input | 1 | Video retrace pulse |
| flagEnable | input | 3 | Enables: [2] A20, [1] VGA timer, [0] retrace |
| extSmiN | input | NUM_EXT | Asynchronous active-low external SMI inputs |
| timerPending | input | GRP_W | Timer and trap group pending vector |
| lpcPending | input | GRP_W | LPC group pending vector |
| acpiPending | input | GRP_W | ACPI access group pending vector |
| audioPending | input | GRP_W | Audio group pending vector |
| pmPending | input | GRP_W | Power-management group pending vector |
| smiReq | output | 1 | Combined SMI request |

## Verification
The bench uses the default parameters: eight external pins, a two-stage synchronizer and 4-bit group vectors. With the two-stage synchronizer, a pin edge becomes visible three edges after it is driven. Four idle cycles are therefore enough to see the edge and to confirm that a steady low level does not trigger again. With eight pins, every top-level bit fits inside a word of 16 bits, so the fully loaded value 0x07EF can be read. The same read shows that the reserved bits stay at 0.

// File: rtl/smi_hub_pkg.sv
package smi_hub_pkg;
  localparam int WORD_W = 16;

  // Bit positions in the top-level word.
  localparam int POS_PM    = 0;
  localparam int POS_AUDIO = 1;
  localparam int POS_ACPI  = 2;
  localparam int POS_LPC   = 3;
  localparam int POS_RTR   = 5;
  localparam int POS_VGA   = 6;
  localparam int POS_A20   = 7;
  localparam int POS_SW    = 8;
  localparam int POS_TMR   = 9;
  localparam int POS_EXT   = 10;

  // Local read-to-clear flags, indexed 0 sw, 1 retrace, 2 vga, 3 a20.
  localparam int NUM_FLAGS = 4;

  typedef struct packed {
    logic rdTop;   // clearing read of the top-level word
    logic clrExt;  // write-one-to-clear of the external pending bits
  } hubStrobe_t;
endpackage

// File: rtl/smi_hub_ctrl.sv
module smi_hub_ctrl
  import smi_hub_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int TOP_ADDR = 0,
  parameter int EXT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [WORD_W-1:0] topWord,
  input  logic [WORD_W-1:0] extWord,
  output hubStrobe_t        strobe,
  output logic [WORD_W-1:0] busRdata
);
  localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(TOP_ADDR);
  localparam logic [ADDR_W-1:0] EXT_A = ADDR_W'(EXT_ADDR);

  logic hitTop;
  logic hitExt;

  assign hitTop = (busAddr == TOP_A);
  assign hitExt = (busAddr == EXT_A);

  always_comb begin
    strobe        = '0;
    strobe.rdTop  = busRd && hitTop;
    strobe.clrExt = busWr && hitExt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (busRd) begin
      if (hitTop)      busRdata <= topWord;
      else if (hitExt) busRdata <= extWord;
      else             busRdata <= '0;
    end else begin
      busRdata <= '0;
    end
  end
endmodule

// File: rtl/smi_hub_datapath.sv
module smi_hub_datapath
  import smi_hub_pkg::*;
#(
  parameter int NUM_EXT     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int GRP_W       = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  hubStrobe_t         strobe,
  input  logic [NUM_EXT-1:0] clrMask,
  input  logic               swSmiPulse,
  input  logic               a20TogglePulse,
  input  logic               vgaTimerPulse,
  input  logic               retracePulse,
  input  logic [2:0]         flagEnable,
  input  logic [NUM_EXT-1:0] extSmiN,
  input  logic [GRP_W-1:0]   timerPending,
  input  logic [GRP_W-1:0]   lpcPending,
  input  logic [GRP_W-1:0]   acpiPending,
  input  logic [GRP_W-1:0]   audioPending,
  input  logic [GRP_W-1:0]   pmPending,
  output logic [WORD_W-1:0]  topWord,
  output logic [WORD_W-1:0]  extWord
);
  logic [NUM_FLAGS-1:0] flagSet;
  logic [NUM_FLAGS-1:0] flagQ;
  logic [NUM_EXT-1:0]   extFall;
  logic [NUM_EXT-1:0]   extPend;

  // Gated set requests for the local flags.
  assign flagSet[0] = swSmiPulse;
  assign flagSet[1] = retracePulse   & flagEnable[0];
  assign flagSet[2] = vgaTimerPulse  & flagEnable[1];
  assign flagSet[3] = a20TogglePulse & flagEnable[2];

  // Set wins over the clearing read so no event is lost.
  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) flagQ[f] <= 1'b0;
      else       flagQ[f] <= flagSet[f] | (flagQ[f] & ~strobe.rdTop);
    end
  end

  // Per-pin synchronizer, falling-edge detector and pending bit.
  for (genvar i = 0; i < NUM_EXT; i++) begin : g_pin
    logic [SYNC_STAGES-1:0] syncChain;
    logic                   lastLevel;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncChain <= '1;
        lastLevel <= 1'b1;
      end else begin
        syncChain <= {syncChain[SYNC_STAGES-2:0], extSmiN[i]};
        lastLevel <= syncChain[SYNC_STAGES-1];
      end
    end

    assign extFall[i] = lastLevel & ~syncChain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
      if (!rstN) extPend[i] <= 1'b0;
      else       extPend[i] <= extFall[i] | (extPend[i] & ~(strobe.clrExt & clrMask[i]));
    end
  end

  assign extWord = WORD_W'(extPend);

  always_comb begin
    topWord            = '0;
    topWord[POS_PM]    = |pmPending;
    topWord[POS_AUDIO] = |audioPending;
    topWord[POS_ACPI]  = |acpiPending;
    topWord[POS_LPC]   = |lpcPending;
    topWord[POS_RTR]   = flagQ[1];
    topWord[POS_VGA]   = flagQ[2];
    topWord[POS_A20]   = flagQ[3];
    topWord[POS_SW]    = flagQ[0];
    topWord[POS_TMR]   = |timerPending;
    topWord[POS_EXT]   = |extPend;
  end
endmodule

// File: rtl/smi_status_hub.sv
module smi_status_hub
  import smi_hub_pkg::*;
#(
  parameter int NUM_EXT     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int GRP_W       = 4,
  parameter int ADDR_W      = 4,
  parameter int TOP_ADDR    = 0,
  parameter int EXT_ADDR    = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busRd,
  input  logic               busWr,
  input  logic [15:0]        busWdata,
  output logic [15:0]        busRdata,
  input  logic               swSmiPulse,
  input  logic               a20TogglePulse,
  input  logic               vgaTimerPulse,
  input  logic               retracePulse,
  input  logic [2:0]         flagEnable,
  input  logic [NUM_EXT-1:0] extSmiN,
  input  logic [GRP_W-1:0]   timerPending,
  input  logic [GRP_W-1:0]   lpcPending,
  input  logic [GRP_W-1:0]   acpiPending,
  input  logic [GRP_W-1:0]   audioPending,
  input  logic [GRP_W-1:0]   pmPending,
  output logic               smiReq
);
  hubStrobe_t        strobe;
  logic [WORD_W-1:0] topWord;
  logic [WORD_W-1:0] extWord;

  if (NUM_EXT < WORD_W) begin : g_spare
    logic unusedWdata;
    assign unusedWdata = ^busWdata[WORD_W-1:NUM_EXT];
  end

  smi_hub_ctrl #(
    .ADDR_W  (ADDR_W),
    .TOP_ADDR(TOP_ADDR),
    .EXT_ADDR(EXT_ADDR)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .topWord (topWord),
    .extWord (extWord),
    .strobe  (strobe),
    .busRdata(busRdata)
  );

  smi_hub_datapath #(
    .NUM_EXT    (NUM_EXT),
    .SYNC_STAGES(SYNC_STAGES),
    .GRP_W      (GRP_W)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .clrMask       (busWdata[NUM_EXT-1:0]),
    .swSmiPulse    (swSmiPulse),
    .a20TogglePulse(a20TogglePulse),
    .vgaTimerPulse (vgaTimerPulse),
    .retracePulse  (retracePulse),
    .flagEnable    (flagEnable),
    .extSmiN       (extSmiN),
    .timerPending  (timerPending),
    .lpcPending    (lpcPending),
    .acpiPending   (acpiPending),
    .audioPending  (audioPending),
    .pmPending     (pmPending),
    .topWord       (topWord),
    .extWord       (extWord)
  );

  assign smiReq = |topWord;
endmodule

// File: rtl/smi_status_hub_chk.sv
module smi_status_hub_chk #(
  parameter int ADDR_W   = 4,
  parameter int GRP_W    = 4,
  parameter int TOP_ADDR = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic [15:0]       busRdata,
  input logic              swSmiPulse,
  input logic              a20TogglePulse,
  input logic [2:0]        flagEnable,
  input logic [GRP_W-1:0]  acpiPending,
  input logic [GRP_W-1:0]  pmPending,
  input logic [15:0]       topWord,
  input logic              smiReq
);
  logic topRead;
  assign topRead = busRd && (busAddr == ADDR_W'(TOP_ADDR));

  a_r2_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    topRead && topWord[8] && !swSmiPulse |=> !topWord[8]);

  a_r3_gate_blocks: assert property (@(posedge clk) disable iff (!rstN)
    a20TogglePulse && !flagEnable[2] && !topWord[7] && !$past(a20TogglePulse) |=> !topWord[7]);

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    topRead && swSmiPulse |=> topWord[8]);

  a_r5_summary: assert property (@(posedge clk) disable iff (!rstN)
    (|acpiPending) |-> topWord[2]);

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    topRead |=> (busRdata[4] == 1'b0) && (busRdata[15:11] == 5'd0));

  a_r9_request: assert property (@(posedge clk) disable iff (!rstN)
    (|pmPending) |-> smiReq);

  a_r10_latency: assert property (@(posedge clk) disable iff (!rstN)
    topRead |=> busRdata == $past(topWord));
endmodule

bind smi_status_hub smi_status_hub_chk #(
  .ADDR_W  (ADDR_W),
  .GRP_W   (GRP_W),
  .TOP_ADDR(TOP_ADDR)
) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .busAddr       (busAddr),
  .busRd         (busRd),
  .busRdata      (busRdata),
  .swSmiPulse    (swSmiPulse),
  .a20TogglePulse(a20TogglePulse),
  .flagEnable    (flagEnable),
  .acpiPending   (acpiPending),
  .pmPending     (pmPending),
  .topWord       (topWord),
  .smiReq        (smiReq)
);

// File: tb/smi_status_hub_tb_top.sv
module smi_status_hub_tb_top;
  localparam int NUM_EXT = 8;
  localparam int GRP_W   = 4;
  localparam int ADDR_W  = 4;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [ADDR_W-1:0]  busAddr = '0;
  logic               busRd = 1'b0;
  logic               busWr = 1'b0;
  logic [15:0]        busWdata = '0;
  logic [15:0]        busRdata;
  logic               swSmiPulse = 1'b0;
  logic               a20TogglePulse = 1'b0;
  logic               vgaTimerPulse = 1'b0;
  logic               retracePulse = 1'b0;
  logic [2:0]         flagEnable = '0;
  logic [NUM_EXT-1:0] extSmiN = '1;
  logic [GRP_W-1:0]   timerPending = '0;
  logic [GRP_W-1:0]   lpcPending = '0;
  logic [GRP_W-1:0]   acpiPending = '0;
  logic [GRP_W-1:0]   audioPending = '0;
  logic [GRP_W-1:0]   pmPending = '0;
  logic               smiReq;

  int errCount = 0;
  int chkCount = 0;
  logic rdSeen = 1'b0;
  logic [15:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;  // 50 MHz

  smi_status_hub #(.NUM_EXT(NUM_EXT), .GRP_W(GRP_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .swSmiPulse(swSmiPulse),
    .a20TogglePulse(a20TogglePulse), .vgaTimerPulse(vgaTimerPulse),
    .retracePulse(retracePulse), .flagEnable(flagEnable), .extSmiN(extSmiN),
    .timerPending(timerPending), .lpcPending(lpcPending), .acpiPending(acpiPending),
    .audioPending(audioPending), .pmPending(pmPending), .smiReq(smiReq)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  // Driver: issues a read and pushes the expected word to the scoreboard.
  task automatic doRead(input logic [ADDR_W-1:0] a, input logic [15:0] exp, input string tag);
    busAddr = a;
    busRd = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    busAddr = a;
    busWdata = d;
    busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    busWdata = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Monitor: compares each read result one cycle after its strobe.
  always @(posedge clk) rdSeen <= busRd && rstN;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        chkCount++; errCount++;
        $display("FAIL scoreboard: actual=0x%04h expected=none", busRdata);
      end else begin
        check(busRdata, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errCount++; chkCount++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

  initial begin
    idle(3);
    check(busRdata, 16'h0, "R1 rdata in reset");
    check({15'd0, smiReq}, 16'h0, "R1 smiReq in reset");
    rstN = 1'b1;
    idle(1);
    doRead(0, 16'h0000, "R1 word after reset");
    doRead(1, 16'h0000, "R1 ext after reset");

    // R2 software flag
    swSmiPulse = 1'b1; idle(1); swSmiPulse = 1'b0;
    check({15'd0, smiReq}, 16'h1, "R9 req with flag");
    doRead(0, 16'h0100, "R2 set");
    doRead(0, 16'h0000, "R2 cleared");
    check({15'd0, smiReq}, 16'h0, "R9 req idle");

    // R3 gated flags
    a20TogglePulse = 1; vgaTimerPulse = 1; retracePulse = 1; idle(1);
    a20TogglePulse = 0; vgaTimerPulse = 0; retracePulse = 0;
    doRead(0, 16'h0000, "R3 disabled");
    flagEnable = 3'b111;
    a20TogglePulse = 1; vgaTimerPulse = 1; retracePulse = 1; idle(1);
    a20TogglePulse = 0; vgaTimerPulse = 0; retracePulse = 0;
    doRead(0, 16'h00E0, "R3 enabled");
    doRead(0, 16'h0000, "R3 cleared");
    flagEnable = 3'b010;
    a20TogglePulse = 1; vgaTimerPulse = 1; retracePulse = 1; idle(1);
    a20TogglePulse = 0; vgaTimerPulse = 0; retracePulse = 0;
    doRead(0, 16'h0040, "R3 vga only");
    flagEnable = 3'b101;
    a20TogglePulse = 1; vgaTimerPulse = 1; retracePulse = 1; idle(1);
    a20TogglePulse = 0; vgaTimerPulse = 0; retracePulse = 0;
    doRead(0, 16'h00A0, "R3 a20 and retrace");

    // R4 set during clearing read
    swSmiPulse = 1'b1; idle(1); swSmiPulse = 1'b0;
    swSmiPulse = 1'b1;
    doRead(0, 16'h0100, "R4 old value");
    swSmiPulse = 1'b0;
    doRead(0, 16'h0100, "R4 kept");
    doRead(0, 16'h0000, "R4 then cleared");

    // R5 summaries
    lpcPending = 4'b0100;
    doRead(0, 16'h0008, "R5 lpc");
    doRead(0, 16'h0008, "R5 not cleared");
    timerPending = 4'b1000; acpiPending = 4'b0001; audioPending = 4'b0010; pmPending = 4'b0100;
    doRead(0, 16'h020F, "R5 all groups");
    timerPending = '0; lpcPending = '0; acpiPending = '0; audioPending = '0;
    idle(1);
    check({15'd0, smiReq}, 16'h1, "R9 pm only");
    pmPending = '0;
    idle(1);
    check({15'd0, smiReq}, 16'h0, "R9 groups clear");

    // R6 / R7 external pins
    extSmiN[3] = 1'b0; idle(4);
    doRead(1, 16'h0008, "R6 pin3 edge");
    check({15'd0, smiReq}, 16'h1, "R9 ext pending");
    doRead(0, 16'h0400, "R7 bit10");
    doRead(0, 16'h0400, "R7 bit10 not cleared");
    doRead(1, 16'h0008, "R7 ext read no clear");
    extSmiN[3] = 1'b1; idle(4);
    doRead(1, 16'h0008, "R6 rise no new");
    extSmiN[5] = 1'b0; idle(4);
    doRead(1, 16'h0028, "R6 pin5 edge");
    doWrite(1, 16'h0008);
    doRead(1, 16'h0020, "R7 w1c pin3");
    doWrite(1, 16'h0020);
    idle(3);
    doRead(1, 16'h0000, "R6 steady low no retrigger");
    doRead(0, 16'h0000, "R7 bit10 cleared");
    extSmiN[5] = 1'b1; idle(4);

    // R8 reserved bits and writes to the top word
    swSmiPulse = 1'b1; idle(1); swSmiPulse = 1'b0;
    doWrite(0, 16'hFFFF);
    doRead(0, 16'h0100, "R8 write ignored");
    flagEnable = 3'b111;
    swSmiPulse = 1; a20TogglePulse = 1; vgaTimerPulse = 1; retracePulse = 1;
    timerPending = '1; lpcPending = '1; acpiPending = '1; audioPending = '1; pmPending = '1;
    extSmiN[0] = 1'b0;
    idle(1);
    swSmiPulse = 0; a20TogglePulse = 0; vgaTimerPulse = 0; retracePulse = 0;
    idle(4);
    doRead(0, 16'h07EF, "R8 full word");
    timerPending = '0; lpcPending = '0; acpiPending = '0; audioPending = '0; pmPending = '0;
    extSmiN[0] = 1'b1;
    doWrite(1, 16'h00FF);
    idle(4);
    doRead(0, 16'h0000, "R8 all cleared");

    // R10 unmapped address and idle data
    doRead(5, 16'h0000, "R10 unmapped");
    swSmiPulse = 1'b1; idle(1); swSmiPulse = 1'b0;
    doRead(0, 16'h0100, "R10 read data");
    idle(1);
    check(busRdata, 16'h0000, "R10 idle zero");

    idle(2);
    if (expQ.size() != 0) begin
      chkCount++; errCount++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending", expQ.size());
    end
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end
endmodule